// File: doc/BRIEF.md
# FSK Switchable PLL Divider Pair

This block holds the two programmable dividers of a frequency synthesiser loop. The reference divider turns a reference-clock enable stream into comparison pulses. The feedback divider turns a VCO-side enable stream into feedback pulses. The feedback divider is a pulse-swallow structure: a prescaler that divides by 64 or 65, a swallow counter, and a program counter. Together they give a total feedback ratio of 64·N + A.

Two complete parameter sets (A, N, M) are held at the inputs. In the switching modulation mode, a live data bit picks the set, so the loop moves between two output frequencies and produces two-level FSK. In every other mode the second set is used.

A new set never cuts a division period short. Each divider captures its parameters at the start of a period and keeps them until that period ends. Each period ends with a single-cycle pulse. Both dividers run in the `clk` domain and count only the cycles in which their enable is high.

Top module: `fsk_pll_divider`

## Requirements
- R1: While `rst_n` is low, and after reset until enough enables have been counted, `ref_pulse` and `fb_pulse` are low. No pulse appears while both enables are held low.
- R2: When N ≥ A, `fb_pulse` fires once every 64·N + A cycles that have `vco_en` high. Cycles with `vco_en` low are not counted.
- R3: When N < A, every prescaler cycle of the period divides by 65, so the period is 65·N. An N field of 0 acts as N = 1.
- R4: `ref_pulse` fires once every M cycles that have `ref_en` high. An M field of 0 acts as M = 1.
- R5: Each pulse is one clock wide. It is registered, so it is high in the cycle after the clock edge at which the enable that completes the period was counted.
- R6: When `mod_mode` is 2'b10, `fsk_bit` = 0 selects set 0 and `fsk_bit` = 1 selects set 1.
- R7: When `mod_mode` is 2'b00, 2'b01 or 2'b11, set 1 is used whatever the value of `fsk_bit`.
- R8: A change of the selected set, made by `fsk_bit`, `mod_mode` or the set fields, takes effect at the start of the next division period of each divider. The period in progress completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One reference-clock event per high cycle |
| vco_en | input | 1 | One VCO-side event per high cycle |
| mod_mode | input | 2 | Modulation mode; 2'b10 lets the data bit choose the set |
| fsk_bit | input | 1 | Serial data bit that selects the set in switching mode |
| set0_a | input | A_W (6) | Swallow count, set 0 |
| set0_n | input | N_W (12) | Program count, set 0 |
| set0_m | input | M_W (10) | Reference division, set 0 |
| set1_a | input | A_W (6) | Swallow count, set 1 |
| set1_n | input | N_W (12) | Program count, set 1 |
| set1_m | input | M_W (10) | Reference division, set 1 |
| ref_pulse | output | 1 | One-cycle comparison pulse per M reference events |
| fb_pulse | output | 1 | One-cycle feedback pulse per full feedback period |

## Verification
The feedback divider is swept over every (A, N) pair with N up to 4 and A up to N, with gaps in the VCO enable. A period of exactly 64·N + A enables separates a correct swallow count from an off-by-one prescaler or from counting idle cycles. A separate group of cases with N < A and with zero fields checks the 65·N and clamped results, which the normal formula would get wrong.

The set-selection cases use two sets whose ratios differ. They run every mode with both data values, so a mode-decode fault shows as the wrong period. A data edge placed in the middle of a period tells a boundary-aligned switch from an immediate one: the period that ends next must still show the old ratio.

Finally, the full-size example sets are measured in both data states (ratios 8603 and 8777, reference 99 and 101).

// File: rtl/fsk_div_pkg.sv
package fsk_div_pkg;

  typedef enum logic [1:0] {
    MOD_PLAIN0 = 2'b00,
    MOD_PLAIN1 = 2'b01,
    MOD_SWITCH = 2'b10,
    MOD_PLAIN3 = 2'b11
  } mod_sel_e;

  // Returns the index of the active divider set.
  function automatic logic pick_set(input logic [1:0] mode, input logic bit_in);
    if (mode == MOD_SWITCH) return bit_in;
    return 1'b1;
  endfunction

  // Total feedback ratio for a swallow count a and program count n.
  function automatic int unsigned fb_span(input int unsigned a, input int unsigned n,
                                          input int unsigned pre);
    int unsigned n_eff;
    n_eff = (n == 0) ? 1 : n;
    if (a <= n_eff) return pre * n_eff + a;
    return (pre + 1) * n_eff;
  endfunction

endpackage

// File: rtl/fsk_set_select.sv
module fsk_set_select #(
  parameter int A_W = 6,
  parameter int N_W = 12,
  parameter int M_W = 10
) (
  input  logic [1:0]     mod_mode,
  input  logic           fsk_bit,
  input  logic [A_W-1:0] set0_a,
  input  logic [N_W-1:0] set0_n,
  input  logic [M_W-1:0] set0_m,
  input  logic [A_W-1:0] set1_a,
  input  logic [N_W-1:0] set1_n,
  input  logic [M_W-1:0] set1_m,
  output logic [A_W-1:0] a_sel,
  output logic [N_W-1:0] n_sel,
  output logic [M_W-1:0] m_sel
);
  import fsk_div_pkg::*;

  logic           use_one;
  logic [N_W-1:0] n_raw;
  logic [M_W-1:0] m_raw;

  assign use_one = pick_set(mod_mode, fsk_bit);
  assign a_sel   = use_one ? set1_a : set0_a;
  assign n_raw   = use_one ? set1_n : set0_n;
  assign m_raw   = use_one ? set1_m : set0_m;

  // A zero count would never terminate a period; treat it as one.
  assign n_sel = (n_raw == '0) ? N_W'(1) : n_raw;
  assign m_sel = (m_raw == '0) ? M_W'(1) : m_raw;
endmodule

// File: rtl/fsk_ref_divider.sv
module fsk_ref_divider #(
  parameter int M_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [M_W-1:0] m_sel,
  output logic           wrap,
  output logic           at_start,
  output logic [M_W-1:0] m_hold
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] m_cur;

  assign at_start = (cnt == '0);
  assign m_cur    = at_start ? m_sel : m_hold;
  assign wrap     = en && (cnt == m_cur - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      m_hold <= '0;
    end else if (en) begin
      if (at_start) m_hold <= m_sel;
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_dual_prescaler.sv
module fsk_dual_prescaler #(
  parameter int PRE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic plus1,
  output logic tick,
  output logic cnt_zero
);
  localparam int PW = $clog2(PRE + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  assign lim      = plus1 ? PW'(PRE) : PW'(PRE - 1);
  assign tick     = en && (cnt == lim);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fsk_swallow_counter.sv
module fsk_swallow_counter #(
  parameter int A_W = 6,
  parameter int N_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_en,
  input  logic           tick,
  input  logic           pre_zero,
  input  logic [A_W-1:0] a_sel,
  input  logic [N_W-1:0] n_sel,
  output logic           plus1,
  output logic           wrap,
  output logic           at_start,
  output logic [A_W-1:0] a_hold,
  output logic [N_W-1:0] n_hold
);
  logic [N_W-1:0] k;
  logic [A_W-1:0] a_cur;
  logic [N_W-1:0] n_cur;

  assign at_start = (k == '0) && pre_zero;
  assign a_cur    = at_start ? a_sel : a_hold;
  assign n_cur    = at_start ? n_sel : n_hold;
  assign plus1    = k < N_W'(a_cur);
  assign wrap     = tick && (k == n_cur - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold <= '0;
      n_hold <= '0;
    end else if (vco_en && at_start) begin
      a_hold <= a_sel;
      n_hold <= n_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    k <= '0;
    else if (tick) k <= wrap ? '0 : k + 1'b1;
  end
endmodule

// File: rtl/fsk_pll_divider.sv
module fsk_pll_divider #(
  parameter int A_W = 6,
  parameter int N_W = 12,
  parameter int M_W = 10,
  parameter int PRE = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_en,
  input  logic           vco_en,
  input  logic [1:0]     mod_mode,
  input  logic           fsk_bit,
  input  logic [A_W-1:0] set0_a,
  input  logic [N_W-1:0] set0_n,
  input  logic [M_W-1:0] set0_m,
  input  logic [A_W-1:0] set1_a,
  input  logic [N_W-1:0] set1_n,
  input  logic [M_W-1:0] set1_m,
  output logic           ref_pulse,
  output logic           fb_pulse
);
  logic [A_W-1:0] a_sel;
  logic [N_W-1:0] n_sel;
  logic [M_W-1:0] m_sel;
  logic           ref_wrap, ref_at_start;
  logic [M_W-1:0] ref_m_hold;
  logic           pre_tick, pre_zero, plus1;
  logic           fb_wrap, fb_at_start;
  logic [A_W-1:0] fb_a_hold;
  logic [N_W-1:0] fb_n_hold;

  fsk_set_select #(.A_W(A_W), .N_W(N_W), .M_W(M_W)) u_sel (
    .mod_mode(mod_mode), .fsk_bit(fsk_bit),
    .set0_a(set0_a), .set0_n(set0_n), .set0_m(set0_m),
    .set1_a(set1_a), .set1_n(set1_n), .set1_m(set1_m),
    .a_sel(a_sel), .n_sel(n_sel), .m_sel(m_sel)
  );

  fsk_ref_divider #(.M_W(M_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(ref_en), .m_sel(m_sel),
    .wrap(ref_wrap), .at_start(ref_at_start), .m_hold(ref_m_hold)
  );

  fsk_dual_prescaler #(.PRE(PRE)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(vco_en), .plus1(plus1),
    .tick(pre_tick), .cnt_zero(pre_zero)
  );

  fsk_swallow_counter #(.A_W(A_W), .N_W(N_W)) u_swl (
    .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .tick(pre_tick),
    .pre_zero(pre_zero), .a_sel(a_sel), .n_sel(n_sel),
    .plus1(plus1), .wrap(fb_wrap), .at_start(fb_at_start),
    .a_hold(fb_a_hold), .n_hold(fb_n_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pulse <= 1'b0;
      fb_pulse  <= 1'b0;
    end else begin
      ref_pulse <= ref_wrap;
      fb_pulse  <= fb_wrap;
    end
  end
endmodule

// File: rtl/fsk_pll_divider_chk.sv
module fsk_pll_divider_chk #(
  parameter int A_W = 6,
  parameter int N_W = 12,
  parameter int M_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_en,
  input logic           vco_en,
  input logic           ref_pulse,
  input logic           fb_pulse,
  input logic           fb_wrap,
  input logic           pre_tick,
  input logic           fb_at_start,
  input logic           ref_at_start,
  input logic [A_W-1:0] fb_a_hold,
  input logic [N_W-1:0] fb_n_hold,
  input logic [M_W-1:0] ref_m_hold
);
  AST_REF_PULSE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_en)); // R5
  AST_FB_PULSE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(vco_en)); // R5
  AST_FB_WRAP_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wrap |=> fb_pulse); // R2
  AST_PRESCALE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> vco_en); // R2
  AST_FB_N_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_n_hold) |-> $past(fb_at_start)); // R8
  AST_FB_A_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_a_hold) |-> $past(fb_at_start)); // R8
  AST_REF_M_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_m_hold) |-> $past(ref_at_start)); // R8
endmodule

bind fsk_pll_divider fsk_pll_divider_chk #(.A_W(A_W), .N_W(N_W), .M_W(M_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .fb_wrap(fb_wrap),
  .pre_tick(pre_tick), .fb_at_start(fb_at_start), .ref_at_start(ref_at_start),
  .fb_a_hold(fb_a_hold), .fb_n_hold(fb_n_hold), .ref_m_hold(ref_m_hold)
);

// File: tb/fsk_pll_divider_test.sv
module fsk_pll_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0, vco_en = 1'b0;
  logic [1:0]  mod_mode = 2'b00;
  logic        fsk_bit = 1'b0;
  logic [5:0]  set0_a = '0, set1_a = '0;
  logic [11:0] set0_n = 12'd1, set1_n = 12'd1;
  logic [9:0]  set0_m = 10'd1, set1_m = 10'd1;
  logic        ref_pulse, fb_pulse;

  int  total = 0, bad = 0, cyc = 0;
  int  fb_cnt = 0, ref_cnt = 0, fb_int = 0, ref_int = 0;
  bit  fb_hit, ref_hit, run_en = 0, gap = 0, done = 0;

  always #10 clk = ~clk;

  fsk_pll_divider uut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
    .mod_mode(mod_mode), .fsk_bit(fsk_bit),
    .set0_a(set0_a), .set0_n(set0_n), .set0_m(set0_m),
    .set1_a(set1_a), .set1_n(set1_n), .set1_m(set1_m),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
  );

  function automatic int exp_fb(int a, int n);
    int ne = (n == 0) ? 1 : n;
    if (a > ne) return 65 * ne;
    return 64 * ne + a;
  endfunction

  function automatic int exp_ref(int m);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: observe registered outputs, then drive the next enables.
  task automatic step();
    @(negedge clk);
    fb_hit  = fb_pulse;
    ref_hit = ref_pulse;
    if (fb_hit)  begin fb_int  = fb_cnt;  fb_cnt  = 0; end
    if (ref_hit) begin ref_int = ref_cnt; ref_cnt = 0; end
    vco_en = run_en && (!gap || (cyc % 4 != 3));
    ref_en = run_en && (!gap || (cyc % 3 != 1));
    if (vco_en) fb_cnt++;
    if (ref_en) ref_cnt++;
    cyc++;
  endtask

  task automatic next_fb();
    do step(); while (!fb_hit);
  endtask

  task automatic next_ref();
    do step(); while (!ref_hit);
  endtask

  // The first pulse ends the period already in progress; the next one is measured.
  task automatic meas_fb(output int v);
    next_fb(); next_fb(); v = fb_int;
  endtask

  task automatic meas_ref(output int v);
    next_ref(); next_ref(); v = ref_int;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, pulses;
    repeat (4) @(negedge clk);
    chk("R1 reset ref_pulse", ref_pulse, 0);
    chk("R1 reset fb_pulse", fb_pulse, 0);
    rst_n = 1'b1;
    pulses = 0;
    repeat (20) begin step(); pulses += fb_hit + ref_hit; end
    chk("R1 idle no pulses", pulses, 0);

    run_en = 1; gap = 1;
    // R2: sweep of (A, N) with N >= A on set 1, while the data bit toggles in mode 00
    for (int n = 1; n <= 4; n++)
      for (int a = 0; a <= n; a++) begin
        set1_a = 6'(a); set1_n = 12'(n); fsk_bit = ~fsk_bit;
        meas_fb(v);
        chk($sformatf("R2 a=%0d n=%0d", a, n), v, exp_fb(a, n));
      end
    // R3: swallow count larger than program count, and zero program count
    set1_a = 6'd5; set1_n = 12'd2; meas_fb(v); chk("R3 n<a", v, exp_fb(5, 2));
    set1_a = 6'd0; set1_n = 12'd0; meas_fb(v); chk("R3 n=0 a=0", v, exp_fb(0, 0));
    set1_a = 6'd2; set1_n = 12'd0; meas_fb(v); chk("R3 n=0 a=2", v, exp_fb(2, 0));
    // R4: reference division sweep including zero
    for (int m = 0; m <= 7; m++) begin
      set1_m = 10'(m);
      meas_ref(v);
      chk($sformatf("R4 m=%0d", m), v, exp_ref(m));
    end

    // R6 / R7: mode decode with distinct sets
    set0_a = 6'd0; set0_n = 12'd1; set0_m = 10'd3;
    set1_a = 6'd1; set1_n = 12'd1; set1_m = 10'd4;
    for (int md = 0; md < 4; md++)
      for (int d = 0; d < 2; d++) begin
        mod_mode = 2'(md); fsk_bit = d[0];
        meas_fb(v);
        if (md == 2) chk($sformatf("R6 fb data=%0d", d), v, (d == 1) ? 65 : 64);
        else         chk($sformatf("R7 fb mode=%0d data=%0d", md, d), v, 65);
        meas_ref(v);
        if (md == 2) chk($sformatf("R6 ref data=%0d", d), v, (d == 1) ? 4 : 3);
        else         chk($sformatf("R7 ref mode=%0d data=%0d", md, d), v, 4);
      end

    // R8: data edge in mid-period keeps the running period
    mod_mode = 2'b10; fsk_bit = 1'b0;
    set0_a = 6'd1; set0_n = 12'd2; set0_m = 10'd5;
    set1_a = 6'd3; set1_n = 12'd3; set1_m = 10'd9;
    next_fb(); next_fb();
    repeat (40) step();
    fsk_bit = 1'b1;
    next_fb(); chk("R8 fb old period kept", fb_int, exp_fb(1, 2));
    next_fb(); chk("R8 fb new set next", fb_int, exp_fb(3, 3));
    fsk_bit = 1'b0;
    next_ref(); next_ref();
    repeat (2) step();
    fsk_bit = 1'b1;
    next_ref(); chk("R8 ref old period kept", ref_int, 5);
    next_ref(); chk("R8 ref new set next", ref_int, 9);

    // Full-size example sets, R2/R4/R6
    gap = 0;
    set0_a = 6'd27; set0_n = 12'd134; set0_m = 10'd99;
    set1_a = 6'd9;  set1_n = 12'd137; set1_m = 10'd101;
    fsk_bit = 1'b0;
    meas_fb(v);  chk("R6 R2 example set0", v, 64 * 134 + 27);
    meas_ref(v); chk("R6 R4 example set0", v, 99);
    fsk_bit = 1'b1;
    meas_fb(v);  chk("R6 R2 example set1", v, 64 * 137 + 9);
    meas_ref(v); chk("R6 R4 example set1", v, 101);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule